// File: doc/BRIEF.md
# Sticky Peak Level Meter

This block watches a stereo stream of signed 20-bit audio samples. One left and one right sample arrive on each cycle where the sample strobe is high. For each channel it keeps a 3-bit code for the loudest level seen, measured in 1 dB steps against digital full scale. The code range runs from "quieter than -6 dBFS", through six one-decibel bands, up to "clipping". The block sits on the digital path ahead of any limiting stage and meters every valid sample.

Each channel's code is sticky. It only climbs until the code is read. A read strobe returns the codes currently shown on the outputs, and the codes then start over from zero. If a sample arrives in the same cycle as a read, the fresh sample's code replaces the cleared value, so no audio escapes the meter.

Each channel has its own small state machine with three states:

- **ST_QUIET**: the held code is 0.
- **ST_BAND**: the held code is 1 to 6.
- **ST_CLIP**: the held code is 7.

The transitions are:

- **RAISE**: a valid sample with a larger code, from ST_QUIET or ST_BAND, going to ST_BAND or ST_CLIP.
- **CLEAR**: a read with no sample, from any state to ST_QUIET.
- **RELOAD**: a read with a sample, from any state to the state of the new code.
- **HOLD**: anything else, which keeps the state and the code.

Top module: `peak_meter_top`

## Requirements
- R1: The left and right codes are computed and held independently; a sample on one channel never changes the other channel's code.
- R2: Let the magnitude m be |sample| and FS be 524287. Let T(k) = ceil(FS·10^(-k/20)) for k = 1..6. The code is 0 when m < T(6). For c = 1..6 the code is c when T(7-c) ≤ m and m is below the next threshold up (T(6-c), or FS for c = 6).
- R3: A sample whose magnitude reaches full scale gives code 7 (clipping). The samples that do this are 0x7FFFF, 0x80001 and 0x80000; the most negative code counts as full scale.
- R4: On a valid sample without a read, the held code is replaced by the new code when the new code is larger, and is left unchanged otherwise. The change is visible on the output one clock after the sample.
- R5: During a read cycle the outputs show the held codes. One clock later both codes are 0 if no sample was valid in the read cycle.
- R6: When a read and a valid sample coincide, the codes one clock later equal the new sample's codes, even if these are smaller than the codes held before.
- R7: In a cycle with neither a valid sample nor a read, the held codes do not change, whatever the sample inputs carry.
- R8: While reset is asserted (active low), and right after it, both codes are 0.
- R9: Negative samples are metered by magnitude, giving the same code as the positive sample of equal size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample pair valid strobe |
| smp_left | input | 20 | Left sample, two's complement |
| smp_right | input | 20 | Right sample, two's complement |
| rd_stb | input | 1 | Read strobe: clear codes after this cycle |
| lvl_left | output | 3 | Held peak code, left |
| lvl_right | output | 3 | Held peak code, right |

## Verification
The samples are placed at the middle of each band, with both signs, to tell the seven codes apart and to show that the magnitude is symmetric. The bench also uses the exact integer thresholds and the value one below them, which exposes rounding of T(k). Rising sequences, falling sequences and different levels on the two channels separate sticky maximum behaviour from plain tracking and from crosstalk. Reads with and without a coincident sample separate CLEAR from RELOAD. Sample inputs that change while the strobe is low confirm that HOLD ignores them.

// File: rtl/peak_meter_pkg.sv
package peak_meter_pkg;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_BAND  = 2'd1,
        ST_CLIP  = 2'd2
    } hold_state_e;

endpackage

// File: rtl/level_quantizer.sv
module level_quantizer #(
    parameter int DW     = 20,
    parameter int NBANDS = 6,
    parameter int CW     = $clog2(NBANDS + 2)
) (
    input  logic [DW-1:0] sample,
    output logic [CW-1:0] code
);
    localparam logic [DW-1:0] FULL = {1'b0, {(DW-1){1'b1}}};
    localparam real FULL_R = real'(2.0 ** (DW - 1)) - 1.0;

    logic [DW-1:0] mag;
    logic [NBANDS:0] hit;

    // Two's-complement negate; the most negative code maps to 2^(DW-1).
    assign mag = sample[DW-1] ? (~sample + 1'b1) : sample;

    // Clip compare sits at index NBANDS, band thresholds below it.
    assign hit[NBANDS] = (mag >= FULL);

    for (genvar k = 1; k <= NBANDS; k++) begin : g_thr
        localparam real THR_R = FULL_R * (10.0 ** ((0.0 - k) / 20.0));
        localparam logic [DW-1:0] THR = DW'($rtoi($ceil(THR_R)));
        assign hit[NBANDS-k] = (mag >= THR);
    end

    // Thresholds are monotonic, so the number of hits is the code.
    always_comb begin
        code = '0;
        for (int i = 0; i <= NBANDS; i++) begin
            code = code + CW'(hit[i]);
        end
    end
endmodule

// File: rtl/peak_hold_fsm.sv
module peak_hold_fsm
    import peak_meter_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic          rd,
    input  logic [CW-1:0] code_in,
    output logic [CW-1:0] held
);
    localparam logic [CW-1:0] CLIP_CODE = '1;

    hold_state_e state_q, state_d;
    logic [CW-1:0] code_d;

    function automatic hold_state_e class_of(input logic [CW-1:0] c);
        if (c == '0)
            return ST_QUIET;
        else if (c == CLIP_CODE)
            return ST_CLIP;
        else
            return ST_BAND;
    endfunction

    always_comb begin
        state_d = state_q;
        code_d  = held;
        if (rd) begin
            // RELOAD or CLEAR
            code_d  = vld ? code_in : '0;
            state_d = class_of(code_d);
        end else begin
            unique case (state_q)
                ST_QUIET, ST_BAND: begin
                    if (vld && (code_in > held)) begin
                        // RAISE
                        code_d  = code_in;
                        state_d = class_of(code_in);
                    end
                end
                ST_CLIP: begin
                    // HOLD: nothing exceeds clipping
                end
                default: begin
                    state_d = ST_QUIET;
                    code_d  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_QUIET;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held <= '0;
        else
            held <= code_d;
    end
endmodule

// File: rtl/peak_meter_top.sv
module peak_meter_top #(
    parameter int DW     = 20,
    parameter int NBANDS = 6,
    parameter int CW     = $clog2(NBANDS + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_left,
    input  logic [DW-1:0] smp_right,
    input  logic          rd_stb,
    output logic [CW-1:0] lvl_left,
    output logic [CW-1:0] lvl_right
);
    localparam int NCH = 2;

    logic [DW-1:0] smp_ch  [NCH];
    logic [CW-1:0] qcode   [NCH];
    logic [CW-1:0] held_ch [NCH];
    logic [CW-1:0] qcode_l, qcode_r;

    assign smp_ch[0] = smp_left;
    assign smp_ch[1] = smp_right;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        level_quantizer #(.DW(DW), .NBANDS(NBANDS), .CW(CW)) u_quant (
            .sample (smp_ch[c]),
            .code   (qcode[c])
        );
        peak_hold_fsm #(.CW(CW)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld     (smp_vld),
            .rd      (rd_stb),
            .code_in (qcode[c]),
            .held    (held_ch[c])
        );
    end

    assign qcode_l   = qcode[0];
    assign qcode_r   = qcode[1];
    assign lvl_left  = held_ch[0];
    assign lvl_right = held_ch[1];
endmodule

// File: rtl/peak_meter_chk.sv
module peak_meter_chk #(
    parameter int DW = 20,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_vld,
    input logic          rd_stb,
    input logic [DW-1:0] smp_left,
    input logic [DW-1:0] smp_right,
    input logic [CW-1:0] qcode_l,
    input logic [CW-1:0] qcode_r,
    input logic [CW-1:0] lvl_left,
    input logic [CW-1:0] lvl_right
);
    localparam logic [DW-1:0] POS_FS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_FS = {1'b1, {(DW-1){1'b0}}};

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !smp_vld) |=> (lvl_left == '0 && lvl_right == '0));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && smp_vld) |=>
            (lvl_left == $past(qcode_l) && lvl_right == $past(qcode_r)));

    p_no_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (lvl_left >= $past(lvl_left) && lvl_right >= $past(lvl_right)));

    p_raise_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && smp_vld && qcode_l > lvl_left) |=> (lvl_left == $past(qcode_l)));

    p_raise_right_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && smp_vld && qcode_r > lvl_right) |=> (lvl_right == $past(qcode_r)));

    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !smp_vld) |=> ($stable(lvl_left) && $stable(lvl_right)));

    p_clip_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_left == POS_FS || smp_left == NEG_FS) |-> (qcode_l == '1));

    p_clip_code_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_right == POS_FS || smp_right == NEG_FS) |-> (qcode_r == '1));
endmodule

bind peak_meter_top peak_meter_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .rd_stb    (rd_stb),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .qcode_l   (qcode_l),
    .qcode_r   (qcode_r),
    .lvl_left  (lvl_left),
    .lvl_right (lvl_right)
);

// File: tb/sim_peak_meter_top.sv
`timescale 1ns/1ps
module sim_peak_meter_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic        rd_stb = 1'b0;
    logic [19:0] smp_left = '0;
    logic [19:0] smp_right = '0;
    logic [2:0]  lvl_left, lvl_right;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    peak_meter_top u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .smp_left(smp_left), .smp_right(smp_right), .rd_stb(rd_stb),
        .lvl_left(lvl_left), .lvl_right(lvl_right)
    );

    // Columns: rd, vld, left, right, expected left, expected right (after edge)
    localparam int NV = 12;
    localparam int VEC [NV][6] = '{
        '{0, 1,  280000,  100000, 1, 0},   // R2 bands 1 and 0
        '{0, 1,  100000,  350000, 1, 3},   // R4 left keeps, R1 right rises alone
        '{0, 1,  440000,  310000, 5, 3},   // R4 raise left, right keeps
        '{0, 0,  524287,  524287, 5, 3},   // R7 no strobe, clip ignored
        '{1, 0,       0,       0, 0, 0},   // R5 clear
        '{0, 1, -440000, -500000, 5, 6},   // R9 negative magnitudes
        '{0, 1, -524288,       0, 7, 6},   // R3 most negative clips
        '{1, 1,  100000,  280000, 0, 1},   // R6 reload smaller code
        '{0, 1,  524287, -350000, 7, 3},   // R3 positive full scale
        '{1, 0,       0,       0, 0, 0},   // R5 clear
        '{0, 1,  500000,  390000, 6, 4},   // R2 bands 6 and 4
        '{0, 1,  310000,       0, 6, 4}    // R4 no drop
    };

    function automatic int thr(input int k);
        return $rtoi($ceil(524287.0 * (10.0 ** ((0.0 - k) / 20.0))));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge: apply, cross posedge, sample 1 ns later.
    task automatic step(input bit rd, input bit v, input int l, input int r);
        rd_stb = rd; smp_vld = v;
        smp_left = 20'(l); smp_right = 20'(r);
        @(posedge clk); #1;
        @(negedge clk);
        rd_stb = 1'b0; smp_vld = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset left", int'(lvl_left), 0);
        check("R8 reset right", int'(lvl_right), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", int'({lvl_left, lvl_right}), 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][0] != 0, VEC[i][1] != 0, VEC[i][2], VEC[i][3]);
            check($sformatf("R4 vector %0d left", i), int'(lvl_left), VEC[i][4]);
            check($sformatf("R1 vector %0d right", i), int'(lvl_right), VEC[i][5]);
        end

        // R5: during the read cycle the held codes are still shown
        rd_stb = 1'b1; #2;
        check("R5 read shows left", int'(lvl_left), 6);
        check("R5 read shows right", int'(lvl_right), 4);
        @(posedge clk); #1; @(negedge clk); rd_stb = 1'b0;
        check("R5 cleared", int'({lvl_left, lvl_right}), 0);

        // R2 boundaries at the -1 dB threshold
        step(0, 1, thr(1), thr(1) - 1);
        check("R2 at T1 left", int'(lvl_left), 6);
        check("R2 below T1 right", int'(lvl_right), 5);
        step(1, 0, 0, 0);
        // R2 boundaries at the -6 dB threshold, negative side too (R9)
        step(0, 1, -thr(6), thr(6) - 1);
        check("R9 at -T6 left", int'(lvl_left), 1);
        check("R2 below T6 right", int'(lvl_right), 0);
        step(1, 0, 0, 0);
        step(0, 1, thr(3), -(thr(4) - 1));
        check("R2 at T3 left", int'(lvl_left), 4);
        check("R9 below T4 right", int'(lvl_right), 2);
        // R3: 0x80001 is also full scale
        step(0, 1, 0, -524287);
        check("R3 0x80001 right", int'(lvl_right), 7);
        check("R1 left untouched", int'(lvl_left), 4);

        // R8: reset in mid-run clears
        rst_n = 1'b0; #2;
        check("R8 async reset", int'({lvl_left, lvl_right}), 0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule